// File: doc/BRIEF.md
# TDM Capture-Channel Serializer

This block places six parallel capture samples, four primary channels and two auxiliary channels, onto one serial data line that follows a 256-bit time-division frame. The bit clock and the frame sync come from outside. The block runs on its own system clock, which must be several times faster than the bit clock. It oversamples both inputs and acts on the edges it detects. The frame holds eight 32-bit slots. Each sample occupies the top of its slot, most significant bit first, and the rest of the slot is zero.

A frame begins at the bit-clock rising edge where the frame sync is first seen high. At that moment all six samples and the word-length code are captured together. The first bit of the frame goes onto the line at once, without waiting for a falling edge. Every later bit changes only after a falling edge of the bit clock. A receiver can therefore take each bit on a rising edge. If no new frame sync arrives after the last bit of a frame, the line returns to zero and stays there.

Top module: `tdm_capture_serializer`

## Requirements
- R1: A frame starts at a detected bit-clock rising edge where the frame sync is high and was low at the previous rising edge. A frame sync held high over many rising edges starts only one frame.
- R2: Bit k of the frame (k = 0..255) is the value a receiver takes at the (k+1)-th rising edge after the frame-start edge. Slot s covers bits 32s to 32s+31. The slot order is primary 0, 1, 2, 3, then two empty slots, then auxiliary 0, 1.
- R3: Samples are 24 bits wide. Primary channel c is `prim_samples[24c+23:24c]` and auxiliary channel a is `aux_samples[24a+23:24a]`. Bit b of a slot carries sample bit 23-b, so the most significant bit comes first, at the top of the slot.
- R4: `len_code` selects the valid length L: 0 gives 16, 1 gives 18, 2 gives 20, 3 gives 24. Slot bits b >= L are zero.
- R5: Both empty slots carry all zeros.
- R6: The samples and `len_code` are captured at the frame start. Changes to them during a frame affect only the next frame.
- R7: The slot-0 most significant bit appears on `sdata_out` before the first falling edge after the frame-start edge. It is not changed by that falling edge, so it is still present at the next rising edge.
- R8: Apart from the frame-start launch, `sdata_out` changes only in response to a detected falling edge of the bit clock. Between a rising edge and the following falling edge it holds its value.
- R9: After reset, `sdata_out` is 0 and stays 0 while the bit clock runs without a frame sync.
- R10: When bit 255 has been presented and the next falling edge arrives without a new frame start, `sdata_out` goes to 0 and stays 0 until a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| fsync_in | input | 1 | Frame sync, high at the frame-start rising edge |
| prim_samples | input | 96 | Four primary 24-bit samples, channel 0 in the low bits |
| aux_samples | input | 48 | Two auxiliary 24-bit samples, channel 0 in the low bits |
| len_code | input | 2 | Valid sample length select |
| sdata_out | output | 1 | Serial slot data |

## Verification
The hardest case to reach is the half bit period right after a frame-start edge. The early launch must already be on the line there, and the first falling edge must leave it unchanged. The stimulus drives the bit clock from the bench and samples the line twice in each bit period: once just before each rising edge, as a receiver does, and once shortly after it. This exposes both the early launch and any change between a rising and a falling edge. Frames with a frame sync held over many bit periods, sample changes partway through a frame, and a missing frame sync at the end of a frame reach the R1, R6 and R10 corners.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  typedef enum logic [1:0] {
    ROLE_PRIM,
    ROLE_EMPTY,
    ROLE_AUX
  } slot_role_e;

  // valid sample length for a length-select code
  function automatic int word_len(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // role of a slot position in the frame
  function automatic slot_role_e slot_role(input int slot, input int n_prim,
                                           input int n_empty);
    if (slot < n_prim) return ROLE_PRIM;
    if (slot < n_prim + n_empty) return ROLE_EMPTY;
    return ROLE_AUX;
  endfunction

  // channel index feeding a slot (primary first, auxiliary after)
  function automatic int chan_of_slot(input int slot, input int n_prim,
                                      input int n_empty);
    if (slot < n_prim) return slot;
    if (slot < n_prim + n_empty) return 0;
    return slot - n_empty;
  endfunction

endpackage

// File: rtl/tdm_edge_detect.sv
module tdm_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fsync_in,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fsync_lvl
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] bclk_sr;
  logic [TOP:0] fsync_sr;
  logic         bclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sr  <= '0;
      fsync_sr <= '0;
      bclk_d   <= 1'b0;
    end else begin
      bclk_sr  <= {bclk_sr[TOP-1:0], bclk_in};
      fsync_sr <= {fsync_sr[TOP-1:0], fsync_in};
      bclk_d   <= bclk_sr[TOP];
    end
  end

  assign bclk_rise = bclk_sr[TOP] & ~bclk_d;
  assign bclk_fall = ~bclk_sr[TOP] & bclk_d;
  assign fsync_lvl = fsync_sr[TOP];

endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq #(
  parameter int FRAME_BITS = 256,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  input  logic             fsync_lvl,
  output logic             frame_start,
  output logic             step_evt,
  output logic             stop_evt,
  output logic             first_hold,
  output logic             running,
  output logic [IDX_W-1:0] bit_idx,
  output logic [IDX_W-1:0] next_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic fsync_prev;
  logic hold_evt;

  assign frame_start = bclk_rise & fsync_lvl & ~fsync_prev;
  assign hold_evt    = bclk_fall & running & first_hold;
  assign step_evt    = bclk_fall & running & ~first_hold & (bit_idx != LAST);
  assign stop_evt    = bclk_fall & running & ~first_hold & (bit_idx == LAST);
  assign next_idx    = frame_start ? '0 : bit_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync_prev <= 1'b0;
    end else if (bclk_rise) begin
      fsync_prev <= fsync_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx    <= '0;
      first_hold <= 1'b0;
      running    <= 1'b0;
    end else if (frame_start) begin
      bit_idx    <= '0;
      first_hold <= 1'b1;
      running    <= 1'b1;
    end else if (hold_evt) begin
      first_hold <= 1'b0;
    end else if (step_evt) begin
      bit_idx <= next_idx;
    end else if (stop_evt) begin
      bit_idx <= '0;
      running <= 1'b0;
    end
  end

endmodule

// File: rtl/tdm_slot_bank.sv
module tdm_slot_bank
  import tdm_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int N_PRIM   = 4,
  parameter int N_EMPTY  = 2,
  parameter int N_AUX    = 2,
  parameter int SLOT_W   = 32,
  localparam int N_CH    = N_PRIM + N_AUX,
  localparam int SLOTS   = N_PRIM + N_EMPTY + N_AUX,
  localparam int IDX_W   = $clog2(SLOTS * SLOT_W),
  localparam int POS_W   = $clog2(SLOT_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [N_PRIM*SAMPLE_W-1:0] prim_samples,
  input  logic [N_AUX*SAMPLE_W-1:0]  aux_samples,
  input  logic [1:0]                 len_code,
  input  logic [IDX_W-1:0]           sel_idx,
  output logic                       bit_out,
  output logic [1:0]                 code_q
);
  logic [SAMPLE_W-1:0] live_ch   [N_CH];
  logic [SAMPLE_W-1:0] bank_ch   [N_CH];
  logic [SAMPLE_W-1:0] src_ch    [N_CH];
  logic [SAMPLE_W-1:0] slot_word [SLOTS];
  logic [1:0]          code_src;

  for (genvar c = 0; c < N_PRIM; c++) begin : g_prim_in
    assign live_ch[c] = prim_samples[c*SAMPLE_W +: SAMPLE_W];
  end
  for (genvar a = 0; a < N_AUX; a++) begin : g_aux_in
    assign live_ch[N_PRIM+a] = aux_samples[a*SAMPLE_W +: SAMPLE_W];
  end

  // capture register per channel; while capturing, the live value bypasses it
  for (genvar c = 0; c < N_CH; c++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) bank_ch[c] <= '0;
      else if (capture) bank_ch[c] <= live_ch[c];
    end
    assign src_ch[c] = capture ? live_ch[c] : bank_ch[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= 2'd3;
    else if (capture) code_q <= len_code;
  end
  assign code_src = capture ? len_code : code_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (slot_role(s, N_PRIM, N_EMPTY) == ROLE_EMPTY) begin : g_empty
      assign slot_word[s] = '0;
    end else begin : g_used
      assign slot_word[s] = src_ch[chan_of_slot(s, N_PRIM, N_EMPTY)];
    end
  end

  logic [POS_W-1:0]       pos;
  logic [IDX_W-POS_W-1:0] sel_slot;
  logic [SAMPLE_W-1:0]    shifted;

  always_comb begin
    pos      = sel_idx[POS_W-1:0];
    sel_slot = sel_idx[IDX_W-1:POS_W];
    shifted  = slot_word[sel_slot] << pos;
    bit_out  = (int'(pos) < word_len(code_src)) ? shifted[SAMPLE_W-1] : 1'b0;
  end

endmodule

// File: rtl/tdm_capture_serializer.sv
module tdm_capture_serializer
  import tdm_ser_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int N_PRIM      = 4,
  parameter int N_EMPTY     = 2,
  parameter int N_AUX       = 2,
  parameter int SLOT_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_in,
  input  logic                       fsync_in,
  input  logic [N_PRIM*SAMPLE_W-1:0] prim_samples,
  input  logic [N_AUX*SAMPLE_W-1:0]  aux_samples,
  input  logic [1:0]                 len_code,
  output logic                       sdata_out
);
  localparam int SLOTS      = N_PRIM + N_EMPTY + N_AUX;
  localparam int FRAME_BITS = SLOTS * SLOT_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // named internal events
  logic             bclk_rise;
  logic             bclk_fall;
  logic             fsync_lvl;
  logic             frame_start;
  logic             step_evt;
  logic             stop_evt;
  logic             first_hold;
  logic             running;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] next_idx;
  logic             next_bit;
  logic [1:0]       code_q;

  tdm_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .fsync_in  (fsync_in),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .fsync_lvl (fsync_lvl)
  );

  tdm_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .fsync_lvl   (fsync_lvl),
    .frame_start (frame_start),
    .step_evt    (step_evt),
    .stop_evt    (stop_evt),
    .first_hold  (first_hold),
    .running     (running),
    .bit_idx     (bit_idx),
    .next_idx    (next_idx)
  );

  tdm_slot_bank #(
    .SAMPLE_W (SAMPLE_W),
    .N_PRIM   (N_PRIM),
    .N_EMPTY  (N_EMPTY),
    .N_AUX    (N_AUX),
    .SLOT_W   (SLOT_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (frame_start),
    .prim_samples (prim_samples),
    .aux_samples  (aux_samples),
    .len_code     (len_code),
    .sel_idx      (next_idx),
    .bit_out      (next_bit),
    .code_q       (code_q)
  );

  // line register: launched at frame start, advanced on falling edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdata_out <= 1'b0;
    end else if (frame_start || step_evt) begin
      sdata_out <= next_bit;
    end else if (stop_evt) begin
      sdata_out <= 1'b0;
    end
  end

endmodule

// File: rtl/tdm_capture_serializer_chk.sv
module tdm_capture_serializer_chk
  import tdm_ser_pkg::*;
#(
  parameter int N_PRIM     = 4,
  parameter int N_EMPTY    = 2,
  parameter int SLOT_W     = 32,
  parameter int FRAME_BITS = 256,
  localparam int IDX_W     = $clog2(FRAME_BITS),
  localparam int POS_W     = $clog2(SLOT_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdata_out,
  input logic             bclk_fall,
  input logic             frame_start,
  input logic             first_hold,
  input logic             running,
  input logic [IDX_W-1:0] bit_idx,
  input logic [1:0]       code_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (running && first_hold && bit_idx == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && running && !first_hold && bit_idx != LAST)
      |=> (bit_idx == $past(bit_idx) + 1'b1));

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && int'(bit_idx[POS_W-1:0]) >= word_len(code_q)) |-> !sdata_out);

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slot_role(int'(bit_idx[IDX_W-1:POS_W]), N_PRIM, N_EMPTY) == ROLE_EMPTY)
      |-> !sdata_out);

  p_first_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && first_hold) |=> $stable(sdata_out));

  p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_out) |-> ($past(bclk_fall) || $past(frame_start)));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sdata_out);

endmodule

bind tdm_capture_serializer tdm_capture_serializer_chk #(
  .N_PRIM     (N_PRIM),
  .N_EMPTY    (N_EMPTY),
  .SLOT_W     (SLOT_W),
  .FRAME_BITS (FRAME_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sdata_out   (sdata_out),
  .bclk_fall   (bclk_fall),
  .frame_start (frame_start),
  .first_hold  (first_hold),
  .running     (running),
  .bit_idx     (bit_idx),
  .code_q      (code_q)
);

// File: tb/tb_tdm_capture_serializer.sv
module tb_tdm_capture_serializer;
  localparam int HALF = 4;  // system clocks per bit-clock half period

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_in;
  logic        fsync_in;
  logic [95:0] prim_samples;
  logic [47:0] aux_samples;
  logic [1:0]  len_code;
  logic        sdata_out;

  always #4 clk = ~clk;  // 125 MHz

  tdm_capture_serializer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_in      (bclk_in),
    .fsync_in     (fsync_in),
    .prim_samples (prim_samples),
    .aux_samples  (aux_samples),
    .len_code     (len_code),
    .sdata_out    (sdata_out)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic rx [256];
  logic [31:0] exp_w [8];
  bit   have_prev = 0;
  logic rx_bit;
  logic late_bit;

  // expected slot content, written from the requirements
  function automatic logic [31:0] expect_slot(int s, logic [95:0] p, logic [47:0] a,
                                              logic [1:0] code);
    logic [23:0] src;
    int len;
    if (s < 4) src = p[s*24 +: 24];
    else if (s >= 6) src = a[(s-6)*24 +: 24];
    else return 32'h0;
    case (code)
      2'd0: len = 16;
      2'd1: len = 18;
      2'd2: len = 20;
      default: len = 24;
    endcase
    return {src, 8'h00} & ~(32'hFFFF_FFFF >> len);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // one bit period: fall with new sync level, sample before rise, sample after rise
  task automatic bit_period(input logic fs);
    @(negedge clk);
    bclk_in  = 1'b0;
    fsync_in = fs;
    repeat (HALF) @(negedge clk);
    rx_bit  = sdata_out;
    bclk_in = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    late_bit = sdata_out;
  endtask

  task automatic check_frame(string tag);
    for (int s = 0; s < 8; s++) begin
      logic [31:0] w;
      for (int b = 0; b < 32; b++) w[31-b] = rx[s*32+b];
      if (s == 4 || s == 5)
        chk($sformatf("R5 empty slot %0d (%s)", s, tag), w, exp_w[s]);
      else
        chk($sformatf("R2 R3 slot %0d (%s)", s, tag), w, exp_w[s]);
    end
  endtask

  task automatic play_frame(int fs_len, int change_at, string tag);
    int mism = 0;
    for (int j = 0; j < 256; j++) begin
      bit_period(j < fs_len);
      if (j == 0) begin
        if (have_prev) begin
          rx[255] = rx_bit;
          check_frame(tag);
        end
        for (int s = 0; s < 8; s++)
          exp_w[s] = expect_slot(s, prim_samples, aux_samples, len_code);
        have_prev = 1;
        chk($sformatf("R7 early MSB after frame start (%s)", tag), late_bit, exp_w[0][31]);
      end else begin
        rx[j-1] = rx_bit;
        if (late_bit !== rx_bit) mism++;
        if (j == 1)
          chk($sformatf("R7 MSB kept over first falling edge (%s)", tag), rx_bit, exp_w[0][31]);
      end
      if (j == change_at) begin
        prim_samples = {$urandom, $urandom, $urandom};
        aux_samples  = {$urandom(), $urandom()} >> 16;
        len_code     = len_code + 2'd1;
      end
    end
    chk($sformatf("R8 changes between rise and fall (%s)", tag), mism, 0);
  endtask

  task automatic flush_frame(string tag);
    bit_period(1'b0);
    rx[255] = rx_bit;
    check_frame(tag);
    have_prev = 0;
  endtask

  task automatic t_reset_idle();
    int ones = 0;
    chk("R9 output zero after reset", sdata_out, 0);
    for (int i = 0; i < 20; i++) begin
      bit_period(1'b0);
      if (rx_bit !== 1'b0 || late_bit !== 1'b0) ones++;
    end
    chk("R9 idle without frame sync", ones, 0);
  endtask

  task automatic t_full_width();
    len_code     = 2'd3;
    prim_samples = {24'hF0F0F1, 24'hA5A5A5, 24'h800001, 24'hC3E1F7};
    aux_samples  = {24'h123457, 24'hFEDCBB};
    play_frame(1, -1, "R3 24-bit frame A");
    prim_samples = {24'h0F0F0F, 24'h5A5A5B, 24'h7FFFFE, 24'h3C1E08};
    aux_samples  = {24'hEDCBA9, 24'h013579};
    play_frame(1, -1, "R3 24-bit frame B");
  endtask

  task automatic t_lengths();
    prim_samples = {4{24'hFFFFFF}};
    aux_samples  = {24'hFFFFFF, 24'hABCDEF};
    for (int c = 0; c < 3; c++) begin
      len_code = 2'(c);
      play_frame(1, -1, $sformatf("R4 length code %0d", c));
    end
  endtask

  task automatic t_latch();
    len_code     = 2'd3;
    prim_samples = {24'h112233, 24'h445566, 24'h778899, 24'hAABBCC};
    aux_samples  = {24'hDDEEFF, 24'h102030};
    play_frame(1, 100, "R6 inputs changed mid frame");
    play_frame(1, 40, "R6 next frame takes new inputs");
  endtask

  task automatic t_wide_sync();
    play_frame(32, -1, "R1 sync held 32 bits");
    play_frame(200, -1, "R1 sync held 200 bits");
  endtask

  task automatic t_stop();
    int ones = 0;
    flush_frame("R10 last frame before stop");
    for (int i = 0; i < 20; i++) begin
      bit_period(1'b0);
      if (rx_bit !== 1'b0 || late_bit !== 1'b0) ones++;
    end
    chk("R10 zero after frame ends without sync", ones, 0);
  endtask

  task automatic t_restart();
    len_code     = 2'd1;
    prim_samples = {24'h9E3779, 24'h7F4A7C, 24'h15D1F2, 24'hC0FFEE};
    aux_samples  = {24'hBADF00, 24'h5EED01};
    play_frame(1, -1, "R1 restart from idle");
    flush_frame("R1 restart from idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    bclk_in      = 1'b0;
    fsync_in     = 1'b0;
    prim_samples = '0;
    aux_samples  = '0;
    len_code     = 2'd3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_full_width();
    t_lengths();
    t_latch();
    t_wide_sync();
    t_stop();
    t_restart();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule